// File: doc/BRIEF.md
# Video Memory Port Address Sequencer

This block is the processor-facing access port into a video memory organised as 16-bit words. Software programs a word address one byte at a time, then streams bytes into the low and high halves of successive words, or streams words back out through a two-byte read window. After each access to the chosen half of the word, the address moves forward by a programmable stride. An optional remap rotates part of the address so that a linear stream of writes lands in the order that planar tile data needs.

Reads work one word ahead. Loading either address byte starts a fetch of the word at the new address into a read latch. Each read that advances the address first refills the latch from the address as it stood before the step. The memory side is a single word port. It has an address, byte-lane enables for writes, a read strobe, and read data that returns in the same cycle.

Top module: `vps_vram_port`

## Requirements
- R1: After reset the address is 0, the control byte is 0 (advance on the low half, stride 1, no remap), the read latch is 0, and no memory access is pending.
- R2: Register selects are 0 control, 1 address bits 7:0, 2 address bits 15:8, 3 write low byte, 4 write high byte, 5 read low byte, 6 read high byte. A write to select 1 or 2 raises `mem_rd` in the next cycle at the new, remapped address. The latch captures that word at the end of that cycle.
- R3: With control bit 7 clear, a write to select 3 drives one memory write with `mem_be` = 01 and the byte on bits 7:0, then advances the address. A write to select 4 drives `mem_be` = 10 with the byte on bits 15:8 and leaves the address unchanged.
- R4: With control bit 7 set, the roles swap: a select 4 write advances the address and a select 3 write does not.
- R5: With bit 7 clear, a high write followed by a low write stores the complete word at one address and advances once. With bit 7 set, the same holds for a low write followed by a high write.
- R6: Control bits 1:0 choose the stride: 00 = 1, 01 = 32, 10 = 64, 11 = 128 words.
- R7: Control bits 3:2 choose the remap applied to every memory address. 00 passes the address through. 01 rotates bits 7:0 left by 3, 10 rotates bits 8:0 left by 3, and 11 rotates bits 9:0 left by 3. The bits above the rotated field pass through unchanged.
- R8: A read of select 5 returns latch bits 7:0 and a read of select 6 returns latch bits 15:8. A read of the trigger half (5 when bit 7 is clear, 6 when it is set) also reloads the latch from the pre-step address and then advances. A read of the other half changes neither the latch nor the address.
- R9: The address wraps modulo 65536.
- R10: A data write in the cycle after an address write goes to the new address. The prefetch in that same cycle latches the word's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte |
| mem_addr | output | 16 | Remapped word address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte-lane enables (bit 0 = low byte) |
| mem_wdata | output | 16 | Memory write word |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Memory read word, same cycle |

## Verification
The prefetch that follows an address load and a data write share the one memory port in the same cycle, and both use the same address. The bench provokes this by issuing a data write directly after an address byte, both in a directed sequence and at random. A reference model snapshots the word before applying the write. It then expects the latched value to be that old word, while the memory itself receives the new byte.

// File: rtl/vps_pkg.sv
package vps_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL     = 3'd0,
      SEL_ADDR_LO  = 3'd1,
      SEL_ADDR_HI  = 3'd2,
      SEL_WDATA_LO = 3'd3,
      SEL_WDATA_HI = 3'd4,
      SEL_RDATA_LO = 3'd5,
      SEL_RDATA_HI = 3'd6,
      SEL_NONE     = 3'd7
   } vps_sel_e;

   typedef struct packed {
      logic       hi_trigger;
      logic [1:0] remap;
      logic [1:0] stride;
   } vps_ctl_t;

   function automatic vps_ctl_t vps_ctl_decode(input logic [7:0] b);
      vps_ctl_t c;
      c.hi_trigger = b[7];
      c.remap      = b[3:2];
      c.stride     = b[1:0];
      return c;
   endfunction

endpackage

// File: rtl/vps_addr_remap.sv
module vps_addr_remap #(
   parameter int ADDR_W = 16,
   parameter int BASE_W = 8,
   parameter int ROT    = 3
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int NUM_MODES = 4;

   initial begin
      if (ADDR_W <= BASE_W + NUM_MODES - 2)
         $error("vps_addr_remap: ADDR_W too small for widest remap field");
      if (ROT < 1 || ROT >= BASE_W)
         $error("vps_addr_remap: ROT out of range");
   end

   logic [ADDR_W-1:0] variant [NUM_MODES];

   assign variant[0] = addr_in;

   for (genvar g = 1; g < NUM_MODES; g++) begin : g_rot
      localparam int FW = BASE_W + g - 1;
      assign variant[g] = {addr_in[ADDR_W-1:FW],
                           addr_in[FW-ROT-1:0],
                           addr_in[FW-1:FW-ROT]};
   end

   assign addr_out = variant[mode];

   // Rotation only moves bits, so the number of ones must not change.
   always_comb begin
      if (!$isunknown(addr_in) && !$isunknown(mode))
         assert_popcount_kept_R7: assert ($countones(addr_out) == $countones(addr_in));
   end

endmodule

// File: rtl/vps_stepper.sv
module vps_stepper #(
   parameter int ADDR_W        = 16,
   parameter int STEP_BASE_LOG = 5
) (
   input  logic [ADDR_W-1:0] addr_cur,
   input  logic [1:0]        stride,
   output logic [ADDR_W-1:0] step_inc,
   output logic [ADDR_W-1:0] addr_nxt
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   initial begin
      if (STEP_BASE_LOG + 2 >= ADDR_W)
         $error("vps_stepper: largest stride does not fit the address");
   end

   always_comb begin
      unique case (stride)
         2'd0:    step_inc = ONE;
         2'd1:    step_inc = ONE << STEP_BASE_LOG;
         2'd2:    step_inc = ONE << (STEP_BASE_LOG + 1);
         default: step_inc = ONE << (STEP_BASE_LOG + 2);
      endcase
   end

   assign addr_nxt = addr_cur + step_inc;

endmodule

// File: rtl/vps_read_latch.sv
module vps_read_latch #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   property p_load_capture;
      @(posedge clk) disable iff (!rst_n) load |=> (q == $past(d));
   endproperty
   assert_latch_capture_R8: assert property (p_load_capture);

   property p_hold;
      @(posedge clk) disable iff (!rst_n) !load |=> $stable(q);
   endproperty
   assert_latch_hold_R8: assert property (p_hold);

endmodule

// File: rtl/vps_vram_port.sv
module vps_vram_port
   import vps_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int BASE_W        = 8,
   parameter int ROT           = 3,
   parameter int STEP_BASE_LOG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   output logic              mem_rd,
   input  logic [15:0]       mem_rdata
);
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   initial begin
      if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W)
         $error("vps_vram_port: ADDR_W must lie in 9..16");
   end

   vps_sel_e          sel;
   vps_ctl_t          ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [ADDR_W-1:0] step_inc;
   logic [WORD_W-1:0] latch_q;
   logic              pend_q;

   logic wr_ctl, wr_alo, wr_ahi, wr_dlo, wr_dhi, rd_lo, rd_hi;
   logic addr_load, advance, trig_read;

   assign sel    = vps_sel_e'(reg_sel);
   assign wr_ctl = reg_wr && (sel == SEL_CTRL);
   assign wr_alo = reg_wr && (sel == SEL_ADDR_LO);
   assign wr_ahi = reg_wr && (sel == SEL_ADDR_HI);
   assign wr_dlo = reg_wr && (sel == SEL_WDATA_LO);
   assign wr_dhi = reg_wr && (sel == SEL_WDATA_HI);
   assign rd_lo  = reg_rd && !reg_wr && (sel == SEL_RDATA_LO);
   assign rd_hi  = reg_rd && !reg_wr && (sel == SEL_RDATA_HI);

   assign addr_load = wr_alo || wr_ahi;
   assign advance   = ctl_q.hi_trigger ? (wr_dhi || rd_hi) : (wr_dlo || rd_lo);
   assign trig_read = advance && (rd_lo || rd_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= vps_ctl_decode(reg_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_alo) begin
         addr_q[BYTE_W-1:0] <= reg_wdata;
      end else if (wr_ahi) begin
         addr_q[ADDR_W-1:BYTE_W] <= reg_wdata[ADDR_W-BYTE_W-1:0];
      end else if (advance) begin
         addr_q <= addr_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= addr_load;
   end

   vps_stepper #(
      .ADDR_W        (ADDR_W),
      .STEP_BASE_LOG (STEP_BASE_LOG)
   ) u_step (
      .addr_cur (addr_q),
      .stride   (ctl_q.stride),
      .step_inc (step_inc),
      .addr_nxt (addr_nxt)
   );

   vps_addr_remap #(
      .ADDR_W (ADDR_W),
      .BASE_W (BASE_W),
      .ROT    (ROT)
   ) u_remap (
      .addr_in  (addr_q),
      .mode     (ctl_q.remap),
      .addr_out (mem_addr)
   );

   assign mem_rd    = pend_q || trig_read;
   assign mem_we    = wr_dlo || wr_dhi;
   assign mem_be    = {wr_dhi, wr_dlo};
   assign mem_wdata = {reg_wdata, reg_wdata};

   vps_read_latch #(.WORD_W (WORD_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (mem_rd),
      .d     (mem_rdata),
      .q     (latch_q)
   );

   always_comb begin
      if (rd_hi)      reg_rdata = latch_q[WORD_W-1:BYTE_W];
      else if (rd_lo) reg_rdata = latch_q[BYTE_W-1:0];
      else            reg_rdata = '0;
   end

   property p_prefetch;
      @(posedge clk) disable iff (!rst_n) addr_load |=> mem_rd;
   endproperty
   assert_prefetch_after_load_R2: assert property (p_prefetch);

   property p_advance;
      @(posedge clk) disable iff (!rst_n)
         (advance && !addr_load) |=> (addr_q == $past(addr_q) + $past(step_inc));
   endproperty
   assert_stride_advance_R6: assert property (p_advance);

   // Covers R3 and R4: an access to the other half leaves the address alone.
   property p_no_advance;
      @(posedge clk) disable iff (!rst_n)
         ((wr_dlo || wr_dhi || rd_lo || rd_hi) && !advance) |=> $stable(addr_q);
   endproperty
   assert_other_half_holds_R3: assert property (p_no_advance);

   property p_single_lane;
      @(posedge clk) disable iff (!rst_n) mem_we |-> ($countones(mem_be) == 1);
   endproperty
   assert_single_lane_R5: assert property (p_single_lane);

endmodule

// File: tb/tb_vps_vram_port.sv
module tb_vps_vram_port;
   localparam int CLK_PERIOD = 10;
   localparam int MW         = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_sel = 3'd7;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [15:0] mem_addr;
   logic        mem_we, mem_rd;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata, mem_rdata;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vps_vram_port dut (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
      .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .mem_addr (mem_addr), .mem_we (mem_we), .mem_be (mem_be),
      .mem_wdata (mem_wdata), .mem_rd (mem_rd), .mem_rdata (mem_rdata)
   );

   logic [15:0] bmem [MW];
   logic [15:0] mmem [MW];

   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) bmem[mem_addr[11:0]][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) bmem[mem_addr[11:0]][15:8] <= mem_wdata[15:8];
      end
   end
   assign mem_rdata = bmem[mem_addr[11:0]];

   logic [15:0] m_addr;
   logic [7:0]  m_ctl;
   logic [15:0] m_latch;
   bit          m_pend;

   function automatic logic [15:0] remap_f(input logic [15:0] a, input logic [1:0] m);
      case (m)
         2'd0:    return a;
         2'd1:    return {a[15:8],  a[4:0], a[7:5]};
         2'd2:    return {a[15:9],  a[5:0], a[8:6]};
         default: return {a[15:10], a[6:0], a[9:7]};
      endcase
   endfunction

   function automatic logic [15:0] step_f(input logic [1:0] s);
      case (s)
         2'd0:    return 16'd1;
         2'd1:    return 16'd32;
         2'd2:    return 16'd64;
         default: return 16'd128;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One register operation (or idle when w=r=0), checked against the model.
   task automatic op(input bit w, input bit r, input int sel, input logic [7:0] d, input string xtag);
      logic [15:0] ra, fetched;
      bit trig, adv, trd, exp_rd;
      @(negedge clk);
      reg_wr = w; reg_rd = r; reg_sel = 3'(sel); reg_wdata = d;
      #1;
      trig    = m_ctl[7];
      ra      = remap_f(m_addr, m_ctl[3:2]);
      fetched = mmem[ra[11:0]];
      adv     = (w && ((sel == 3 && !trig) || (sel == 4 && trig))) ||
                (r && ((sel == 5 && !trig) || (sel == 6 && trig)));
      trd     = adv && r;
      exp_rd  = m_pend || trd;
      check(mem_rd == exp_rd, {m_pend ? "R2" : "R8", " mem_rd ", xtag}, 32'(mem_rd), 32'(exp_rd));
      if (exp_rd)
         check(mem_addr == ra, {m_ctl[3:2] != 0 ? "R7" : "R2", " read addr ", xtag}, 32'(mem_addr), 32'(ra));
      if (w && (sel == 3 || sel == 4)) begin
         check(mem_we == 1'b1, {trig ? "R4" : "R3", " we ", xtag}, 32'(mem_we), 32'd1);
         check(mem_be == ((sel == 3) ? 2'b01 : 2'b10), {trig ? "R4" : "R3", " be ", xtag},
               32'(mem_be), (sel == 3) ? 32'd1 : 32'd2);
         check(mem_addr == ra, {m_ctl[3:2] != 0 ? "R7" : "R6", " write addr ", xtag},
               32'(mem_addr), 32'(ra));
         if (sel == 3) begin
            check(mem_wdata[7:0] == d, {"R3 lane ", xtag}, 32'(mem_wdata[7:0]), 32'(d));
            mmem[ra[11:0]][7:0] = d;
         end else begin
            check(mem_wdata[15:8] == d, {"R4 lane ", xtag}, 32'(mem_wdata[15:8]), 32'(d));
            mmem[ra[11:0]][15:8] = d;
         end
      end else begin
         check(mem_we == 1'b0, {"R3 no write ", xtag}, 32'(mem_we), 32'd0);
      end
      if (r && sel == 5)
         check(reg_rdata == m_latch[7:0], {"R8 read lo ", xtag}, 32'(reg_rdata), 32'(m_latch[7:0]));
      if (r && sel == 6)
         check(reg_rdata == m_latch[15:8], {"R8 read hi ", xtag}, 32'(reg_rdata), 32'(m_latch[15:8]));
      if (exp_rd) m_latch = fetched;
      m_pend = 1'b0;
      if (w && sel == 0) m_ctl = d;
      else if (w && sel == 1) begin m_addr[7:0] = d;  m_pend = 1'b1; end
      else if (w && sel == 2) begin m_addr[15:8] = d; m_pend = 1'b1; end
      else if (adv) m_addr = m_addr + step_f(m_ctl[1:0]);
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 3'd7;
   endtask

   task automatic set_addr(input logic [15:0] a, input string t);
      op(1, 0, 1, a[7:0], t);
      op(1, 0, 2, a[15:8], t);
   endtask

   bit done = 1'b0;

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < MW; i++) begin
         bmem[i] = 16'(i * 16'h9E37 + 16'h1234);
         mmem[i] = bmem[i];
      end
      m_addr = 0; m_ctl = 0; m_latch = 0; m_pend = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      check(mem_rd == 1'b0, "R1 no pending fetch", 32'(mem_rd), 32'd0);
      check(mem_addr == 16'h0, "R1 address zero", 32'(mem_addr), 32'd0);
      op(0, 1, 6, 8'h00, "R1 latch zero");
      op(1, 0, 3, 8'h5A, "R1 stride one");
      check(mem_addr == 16'h0001, "R1 after one step", 32'(mem_addr), 32'd1);

      // R5: high then low commits full word, trigger on low
      set_addr(16'h0100, "R5");
      op(1, 0, 4, 8'hAB, "R5 hi first");
      op(1, 0, 3, 8'hCD, "R5 lo commits");
      check(mem_addr == 16'h0101, "R5 single advance", 32'(mem_addr), 32'h0101);
      set_addr(16'h0100, "R5");
      op(0, 0, 7, 8'h00, "R5 idle");
      op(0, 1, 5, 8'h00, "R5 read lo");
      check(m_latch == 16'hABCD, "R5 model word", 32'(m_latch), 32'hABCD);

      // R4: trigger on high half, low then high
      op(1, 0, 0, 8'h80, "R4 ctl");
      set_addr(16'h0200, "R4");
      op(1, 0, 3, 8'h11, "R4 lo no step");
      op(1, 0, 4, 8'h22, "R4 hi steps");
      check(mem_addr == 16'h0201, "R4 advanced once", 32'(mem_addr), 32'h0201);

      // R6: each stride code
      for (int s = 0; s < 4; s++) begin
         op(1, 0, 0, 8'(s), "R6 ctl");
         set_addr(16'h0300, "R6");
         op(1, 0, 3, 8'h33, "R6 step write");
         check(mem_addr == 16'h0300 + step_f(2'(s)), "R6 stride", 32'(mem_addr),
               32'(16'h0300 + step_f(2'(s))));
      end

      // R7: each remap mode
      for (int m = 0; m < 4; m++) begin
         op(1, 0, 0, 8'(m << 2), "R7 ctl");
         set_addr(16'hA2C5, "R7");
         check(mem_addr == remap_f(16'hA2C5, 2'(m)), "R7 remap", 32'(mem_addr),
               32'(remap_f(16'hA2C5, 2'(m))));
         op(1, 0, 3, 8'h77, "R7 write");
      end

      // R8: trigger read refills then steps, other half does not
      op(1, 0, 0, 8'h00, "R8 ctl");
      set_addr(16'h0040, "R8");
      op(0, 0, 7, 8'h00, "R8 idle");
      op(0, 1, 6, 8'h00, "R8 non-trigger read");
      op(0, 1, 5, 8'h00, "R8 trigger read");
      op(0, 1, 5, 8'h00, "R8 trigger read 2");
      check(mem_addr == 16'h0042, "R8 two steps", 32'(mem_addr), 32'h0042);

      // R9: wrap
      set_addr(16'hFFFF, "R9");
      op(1, 0, 3, 8'h99, "R9 last word");
      check(mem_addr == 16'h0000, "R9 wrapped", 32'(mem_addr), 32'h0);

      // R10: data write lands in the prefetch cycle
      op(1, 0, 1, 8'h50, "R10 addr lo");
      op(1, 0, 3, 8'hEE, "R10 write during prefetch");
      op(0, 1, 6, 8'h00, "R10 latch holds old word");

      // Random mix
      for (int k = 0; k < 4000; k++) begin
         int pick;
         pick = int'($urandom_range(0, 99));
         if (pick < 4)       op(1, 0, 0, 8'($urandom) & 8'h8F, "rnd");
         else if (pick < 14) op(1, 0, 1 + int'($urandom_range(0, 1)), 8'($urandom), "rnd");
         else if (pick < 52) op(1, 0, 3 + int'($urandom_range(0, 1)), 8'($urandom), "rnd");
         else if (pick < 92) op(0, 1, 5 + int'($urandom_range(0, 1)), 8'h00, "rnd");
         else                op(0, 0, 7, 8'h00, "rnd");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule